// File: doc/BRIEF.md
# Multi-mode timer/counter

This block is one timer/counter built from two 8-bit count bytes, a low byte and a high byte. A two-bit layout select decides how the bytes are chained. The choices are a 13-bit counter with a 5-bit prescaler in the low byte, a full 16-bit counter, an 8-bit counter that reloads itself from the high byte, or two independent 8-bit counters. Each count step comes from one of two sources: a one-cycle machine-cycle tick or a one-cycle pulse from an external event that has already been qualified. A gate control can make counting depend on the level of an external interrupt pin, which allows the pin's high time to be measured.

When the active counter wraps from all ones to zero, an overflow flag is raised. The counter keeps running after it wraps. Software clears a flag with a clear pulse, and the interrupt controller clears it with an acknowledge pulse. Software loads either count byte with a single-cycle write strobe. Both bytes can always be read on plain output buses.

All pins are plain control and status signals. The block carries no streamed data, so none of its ports uses a valid/ready handshake, and it never applies back-pressure.

Top module: `tmr_unit`

## Requirements
- R1: After reset both count bytes read 0x00 and both overflow flags read 0.
- R2: Outside split layout, the low counter advances by one on each cycle where run=1, (gate=0 or ext_lvl=1) and the selected source is high. The source is `tick` when src_sel=0 and `evt_pulse` when src_sel=1. In any other cycle the count holds.
- R3: Layout 2'b00 (13-bit) counts in bits [4:0] of the low byte. When those bits are 0x1F a step carries into the high byte. Bits [7:5] of the low byte never change except by a write. The wrap from hi=0xFF, lo[4:0]=0x1F sets flag 0.
- R4: Layout 2'b01 (16-bit) counts {hi,lo} as one value. A step with lo=0xFF carries into hi. The wrap from 0xFFFF to 0x0000 sets flag 0.
- R5: Layout 2'b10 (reload) counts only the low byte. A step at lo=0xFF loads lo with the high byte's value, leaves hi unchanged and sets flag 0, all on the same edge.
- R6: Layout 2'b11 (split) runs the low byte as its own 8-bit counter under the R2 qualification, and its wrap sets flag 0. The high byte advances on each cycle with peer_run=1 and tick=1. It ignores run, gate, ext_lvl and src_sel, and its wrap sets flag 1. In the other layouts flag 1 is never set.
- R7: A wrap does not stop counting. The next qualified step continues from the wrapped value.
- R8: A write strobe loads wr_data into its byte on that edge and takes priority over any increment. In layouts 00, 01 and 10, a write to either byte also suppresses that cycle's step and overflow. In layout 11, a write suppresses only the counter of the byte that is written.
- R9: A flag clears on the edge after flagN_clr=1 or ackN=1. If the flag's overflow occurs on that same edge, the flag is set instead.
- R10: cnt_lo and cnt_hi always show the present contents of the count bytes, and ovf_flag0 and ovf_flag1 show the flag registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Layout select: 00 13-bit, 01 16-bit, 10 reload, 11 split |
| run | input | 1 | Run control of this unit |
| gate | input | 1 | When 1, counting also requires ext_lvl high |
| ext_lvl | input | 1 | External interrupt pin level |
| src_sel | input | 1 | 0 selects tick, 1 selects evt_pulse |
| tick | input | 1 | Machine-cycle tick, one clock wide |
| evt_pulse | input | 1 | Qualified external falling-edge pulse |
| peer_run | input | 1 | Run control of the neighbouring unit (split high byte) |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_data | input | 8 | Write data |
| flag0_clr | input | 1 | Software clear for flag 0 |
| flag1_clr | input | 1 | Software clear for flag 1 |
| ack0 | input | 1 | Interrupt acknowledge clear for flag 0 |
| ack1 | input | 1 | Interrupt acknowledge clear for flag 1 |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag0 | output | 1 | Overflow flag 0 |
| ovf_flag1 | output | 1 | Overflow flag 1 |

## Verification
The bench goes after each layout's wrap point:
- In the 13-bit layout, the upper three low-byte bits must survive a prescaler carry. A design that counted all eight bits would show 0xC0 where 0xA0 is expected.
- In the reload layout, the low byte must come back with the high byte's value rather than zero.
- In split layout, the high byte must keep counting with run low and the gate closed. A design that shared the low byte's enable would freeze it.

It also races a clear and an acknowledge against an overflow on the same edge, where a clear-wins design would lose the event. It also writes while a step is pending, where a design that let the increment win would show 0x56 instead of 0x55.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 5;

  typedef enum logic [1:0] {
    LAY_PRE13  = 2'b00,
    LAY_FULL16 = 2'b01,
    LAY_RELOAD = 2'b10,
    LAY_SPLIT  = 2'b11
  } tmr_layout_e;
endpackage

// File: rtl/tmr_enable.sv
module tmr_enable (
  input  logic run,
  input  logic gate,
  input  logic ext_lvl,
  input  logic src_sel,
  input  logic tick,
  input  logic evt_pulse,
  input  logic peer_run,
  output logic step_main,
  output logic step_split_hi
);
  logic gate_open;
  logic src_pulse;

  always_comb begin
    gate_open     = ~gate | ext_lvl;
    src_pulse     = src_sel ? evt_pulse : tick;
    step_main     = run & gate_open & src_pulse;
    step_split_hi = peer_run & tick;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_layout_e  layout,
  input  logic         step_main,
  input  logic         step_split_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         wrap_a,
  output logic         wrap_b
);
  localparam int UPW = W - PW;

  logic [W-1:0]  lo_nxt, hi_nxt;
  logic [PW-1:0] pre_q;
  logic          linked, any_wr, adv_link, adv_lo_split, adv_hi_split;

  always_comb begin
    pre_q        = cnt_lo[PW-1:0];
    linked       = (layout != LAY_SPLIT);
    any_wr       = wr_lo | wr_hi;
    adv_link     = linked & step_main & ~any_wr;
    adv_lo_split = ~linked & step_main & ~wr_lo;
    adv_hi_split = ~linked & step_split_hi & ~wr_hi;
    lo_nxt       = cnt_lo;
    hi_nxt       = cnt_hi;
    wrap_a       = 1'b0;
    wrap_b       = 1'b0;
    unique case (layout)
      LAY_PRE13: if (adv_link) begin
        lo_nxt = {cnt_lo[W-1:PW], pre_q + 1'b1};
        if (&pre_q) begin
          hi_nxt = cnt_hi + 1'b1;
          wrap_a = &cnt_hi;
        end
      end
      LAY_FULL16: if (adv_link) begin
        lo_nxt = cnt_lo + 1'b1;
        if (&cnt_lo) begin
          hi_nxt = cnt_hi + 1'b1;
          wrap_a = &cnt_hi;
        end
      end
      LAY_RELOAD: if (adv_link) begin
        if (&cnt_lo) begin
          lo_nxt = cnt_hi;
          wrap_a = 1'b1;
        end else begin
          lo_nxt = cnt_lo + 1'b1;
        end
      end
      LAY_SPLIT: begin
        if (adv_lo_split) begin
          lo_nxt = cnt_lo + 1'b1;
          wrap_a = &cnt_lo;
        end
        if (adv_hi_split) begin
          hi_nxt = cnt_hi + 1'b1;
          wrap_b = &cnt_hi;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_nxt = wr_data;
    if (wr_hi) hi_nxt = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_nxt;
      cnt_hi <= hi_nxt;
    end
  end

  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAY_PRE13 && !wr_lo) |=> cnt_lo[W-1:PW] == $past(cnt_lo[W-1:PW]))
    else $error("R3 upper low-byte bits moved");
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAY_FULL16 && wrap_a) |=> (cnt_lo == '0 && cnt_hi == '0))
    else $error("R4 16-bit wrap not zero");
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAY_RELOAD && wrap_a && !wr_hi) |=> (cnt_lo == $past(cnt_hi) && $stable(cnt_hi)))
    else $error("R5 reload value wrong");
  a_r6_hi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAY_SPLIT && !step_split_hi && !wr_hi) |=> $stable(cnt_hi))
    else $error("R6 split high byte moved without tick");
  a_r8_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_lo == $past(wr_data))
    else $error("R8 low write lost");
  a_r8_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cnt_hi == $past(wr_data))
    else $error("R8 high write lost");

  initial begin
    a_r3_width: assert (UPW > 0) else $error("R3 prescaler wider than byte");
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic sw_clr,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag <= 1'b0;
    else if (set)            flag <= 1'b1;
    else if (sw_clr || ack)  flag <= 1'b0;
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag)
    else $error("R9 overflow not flagged");
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && (sw_clr || ack)) |=> !flag)
    else $error("R9 flag not cleared");
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !sw_clr && !ack) |=> $stable(flag))
    else $error("R7 flag changed on its own");
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       run,
  input  logic       gate,
  input  logic       ext_lvl,
  input  logic       src_sel,
  input  logic       tick,
  input  logic       evt_pulse,
  input  logic       peer_run,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wr_data,
  input  logic       flag0_clr,
  input  logic       flag1_clr,
  input  logic       ack0,
  input  logic       ack1,
  output logic [7:0] cnt_lo,
  output logic [7:0] cnt_hi,
  output logic       ovf_flag0,
  output logic       ovf_flag1
);
  localparam int NFLAG = 2;

  tmr_layout_e layout;
  logic        step_main, step_split_hi;
  logic [NFLAG-1:0] wrap_v, clr_v, ack_v, flag_v;

  assign layout = tmr_layout_e'(mode);

  tmr_enable u_en (
    .run(run), .gate(gate), .ext_lvl(ext_lvl), .src_sel(src_sel),
    .tick(tick), .evt_pulse(evt_pulse), .peer_run(peer_run),
    .step_main(step_main), .step_split_hi(step_split_hi)
  );

  tmr_count #(.W(CNT_W), .PW(PRE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .layout(layout),
    .step_main(step_main), .step_split_hi(step_split_hi),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .wrap_a(wrap_v[0]), .wrap_b(wrap_v[1])
  );

  assign clr_v = {flag1_clr, flag0_clr};
  assign ack_v = {ack1, ack0};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    tmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(wrap_v[i]),
      .sw_clr(clr_v[i]), .ack(ack_v[i]), .flag(flag_v[i])
    );
  end

  assign ovf_flag0 = flag_v[0];
  assign ovf_flag1 = flag_v[1];

  a_r2_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && mode != 2'b11 && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)))
    else $error("R2 counted while stopped");
  a_r6_flag1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11 && !ovf_flag1) |=> !ovf_flag1)
    else $error("R6 flag 1 set outside split layout");
endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic run = 0, gate = 0, ext_lvl = 0, src_sel = 0, tick = 0, evt_pulse = 0, peer_run = 0;
  logic wr_lo = 0, wr_hi = 0;
  logic [7:0] wr_data = '0;
  logic flag0_clr = 0, flag1_clr = 0, ack0 = 0, ack1 = 0;
  logic [7:0] cnt_lo, cnt_hi;
  logic ovf_flag0, ovf_flag1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tq[$];
  logic [17:0] vq[$];

  always #2.5 clk = ~clk;

  tmr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .gate(gate), .ext_lvl(ext_lvl),
    .src_sel(src_sel), .tick(tick), .evt_pulse(evt_pulse), .peer_run(peer_run),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .flag0_clr(flag0_clr), .flag1_clr(flag1_clr), .ack0(ack0), .ack1(ack1),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag0(ovf_flag0), .ovf_flag1(ovf_flag1)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (vq.size() > 0) begin
      string t;
      logic [17:0] e, a;
      t = tq.pop_front();
      e = vq.pop_front();
      a = {cnt_lo, cnt_hi, ovf_flag0, ovf_flag1};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: lo=%h hi=%h f0=%b f1=%b expected lo=%h hi=%h f0=%b f1=%b",
                 t, a[17:10], a[9:2], a[1], a[0], e[17:10], e[9:2], e[1], e[0]);
      end
    end
  end

  // driver side: push an expectation for the state after the latest edge
  task automatic chk(string t, logic [7:0] lo, logic [7:0] hi, logic f0, logic f1);
    tq.push_back(t);
    vq.push_back({lo, hi, f0, f1});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_byte(bit hi_sel, logic [7:0] d);
    wr_lo = !hi_sel; wr_hi = hi_sel; wr_data = d;
    step();
    wr_lo = 0; wr_hi = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset", 8'h00, 8'h00, 0, 0);
    step();

    // 16-bit layout, writes and enable qualification
    wr_byte(0, 8'h12); wr_byte(1, 8'h34);
    chk("R8 write both bytes", 8'h12, 8'h34, 0, 0);
    tick = 1; step();
    chk("R2 run low holds", 8'h12, 8'h34, 0, 0);
    run = 1; repeat (3) step();
    chk("R2 tick counting", 8'h15, 8'h34, 0, 0);
    gate = 1; ext_lvl = 0; step();
    chk("R2 gate closed", 8'h15, 8'h34, 0, 0);
    ext_lvl = 1; step();
    chk("R2 gate open by pin", 8'h16, 8'h34, 0, 0);
    gate = 0; ext_lvl = 0; src_sel = 1; step();
    chk("R2 event source ignores tick", 8'h16, 8'h34, 0, 0);
    evt_pulse = 1; step(); evt_pulse = 0; src_sel = 0;
    chk("R2 event pulse counts", 8'h17, 8'h34, 0, 0);

    run = 0; wr_byte(0, 8'hFE); wr_byte(1, 8'hFF); run = 1;
    step(); chk("R4 near wrap", 8'hFF, 8'hFF, 0, 0);
    step(); chk("R4 16-bit wrap", 8'h00, 8'h00, 1, 0);
    step(); chk("R7 keeps counting", 8'h01, 8'h00, 1, 0);
    run = 0; wr_byte(0, 8'hFF); wr_byte(1, 8'h12); run = 1;
    step(); chk("R4 carry into high byte", 8'h00, 8'h13, 1, 0);

    run = 0; flag0_clr = 1; step(); flag0_clr = 0;
    chk("R9 software clear", 8'h00, 8'h13, 0, 0);
    wr_byte(0, 8'hFF); wr_byte(1, 8'hFF);
    run = 1; flag0_clr = 1; ack0 = 1; step(); flag0_clr = 0; ack0 = 0; run = 0;
    chk("R9 set beats clear", 8'h00, 8'h00, 1, 0);
    ack0 = 1; step(); ack0 = 0;
    chk("R9 acknowledge clear", 8'h00, 8'h00, 0, 0);

    run = 1; wr_byte(0, 8'h55); run = 0;
    chk("R8 write beats increment", 8'h55, 8'h00, 0, 0);

    // 13-bit layout
    mode = 2'b00; wr_byte(0, 8'hBF); wr_byte(1, 8'h07);
    run = 1; step(); run = 0;
    chk("R3 prescaler carry keeps upper bits", 8'hA0, 8'h08, 0, 0);
    wr_byte(0, 8'hFF); wr_byte(1, 8'hFF);
    run = 1; step(); run = 0;
    chk("R3 13-bit wrap", 8'hE0, 8'h00, 1, 0);
    ack0 = 1; step(); ack0 = 0;
    chk("R10 reads after clear", 8'hE0, 8'h00, 0, 0);

    // reload layout
    mode = 2'b10; wr_byte(1, 8'h80); wr_byte(0, 8'hFE);
    run = 1; step();
    chk("R5 low counts alone", 8'hFF, 8'h80, 0, 0);
    step(); chk("R5 reload from high byte", 8'h80, 8'h80, 1, 0);
    step(); chk("R7 continues after reload", 8'h81, 8'h80, 1, 0);
    run = 0; flag0_clr = 1; step(); flag0_clr = 0;
    chk("R9 clear in reload layout", 8'h81, 8'h80, 0, 0);

    // split layout
    mode = 2'b11; wr_byte(0, 8'hFF); wr_byte(1, 8'hFE);
    peer_run = 1; step();
    chk("R6 high byte on peer run", 8'hFF, 8'hFF, 0, 0);
    step(); chk("R6 high wrap sets flag 1", 8'hFF, 8'h00, 0, 1);
    peer_run = 0; run = 1; step();
    chk("R6 low wrap sets flag 0", 8'h00, 8'h00, 1, 1);
    run = 0; peer_run = 1; gate = 1; ext_lvl = 0; src_sel = 1; step();
    chk("R6 high ignores gate and source", 8'h00, 8'h01, 1, 1);
    peer_run = 0; gate = 0; src_sel = 0; flag1_clr = 1; step(); flag1_clr = 0;
    chk("R9 flag 1 clear", 8'h00, 8'h01, 1, 0);
    peer_run = 1; run = 1; wr_byte(0, 8'h20); peer_run = 0; run = 0;
    chk("R8 split write spares high", 8'h20, 8'h02, 1, 0);

    tick = 0;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule